// File: doc/BRIEF.md
# Column Pivot Search Unit

This unit performs the partial-pivoting search of an LU factorization. A start pulse hands it the column index k and the matrix order n. It then accepts the elements of that column for rows k through n-1, one per clock, as single-precision words qualified by a valid flag. It reports the row whose element has the largest magnitude.

The reported row is absolute: the offset of the winner within the streamed slice plus k. When the result is ready, the unit writes the row into entry k of an on-chip pivot-index table, which downstream logic can read back through a combinational read port. It also raises a zero flag when the winning magnitude is zero, so that the swap and elimination for that column can be skipped. For the last column (k = n-1) no data is consumed and the table entry is simply set to k.

Magnitudes are compared on the bit pattern. The sign bit is dropped and the remaining 31 bits are compared as an unsigned integer, which orders all finite values correctly. The comparison runs in a two-stage pipeline, so input is never stalled.

Top module: `pivot_search`

## Requirements
- R1: After a start with column k and order n (k < n-1), exactly n-k valid elements are consumed, taken as rows k, k+1, ... n-1 in arrival order. piv_row_o equals k plus the offset of the element with the largest magnitude.
- R2: Magnitude is data bit pattern bits [30:0] compared as unsigned. Bit 31 (sign) has no effect, so a negative value can win.
- R3: When several elements share the largest magnitude, the lowest row among them is reported.
- R4: done_o is a one-cycle pulse. If the last element is accepted on clock edge t, done_o is high in the cycle following edge t+2, and piv_row_o and piv_zero_o are valid in that cycle.
- R5: In the done cycle, entry k of the pivot table is written with piv_row_o. tbl_rdata_o shows entry tbl_raddr_i combinationally, from the cycle after done onward.
- R6: piv_zero_o is high in the done cycle exactly when every consumed element has magnitude zero (+0 or -0).
- R7: A start with k >= n-1 consumes no data. done_o follows in the cycle after the edge after the start edge, with piv_row_o = k and piv_zero_o = 0, and table entry k is set to k.
- R8: busy_o rises on the edge that accepts a start and falls on the edge that raises done_o. A start while busy_o is high has no effect on the running search. valid_i while busy_o is low, or after the column is complete, is ignored.
- R9: After reset, busy_o and done_o are low and every table entry reads 0.
- R10: Elements may arrive on consecutive cycles or with idle gaps of any length. The result does not depend on the gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new column search |
| col_i | input | ROW_W | Column index k, sampled with start_i |
| n_i | input | ROW_W+1 | Matrix order n, sampled with start_i |
| valid_i | input | 1 | data_i holds the next column element |
| data_i | input | 32 | Single-precision element |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result pulse |
| piv_row_o | output | ROW_W | Absolute pivot row |
| piv_zero_o | output | 1 | Pivot magnitude is zero |
| tbl_raddr_i | input | ROW_W | Pivot table read address |
| tbl_rdata_o | output | ROW_W | Pivot table read data |

## Verification
The checker tracks its own count of accepted elements and a running maximum magnitude. On every cycle it checks that done_o lands exactly two edges after the last accepted element (or one edge after a final-column start) and is a single pulse. It also checks that the reported row lies within the searched range, that the zero flag matches the observed maximum, and that busy_o only drops together with done_o. Only the bench scenarios can show the exact winning row, covering sign-insensitive ordering, tie breaking toward the lower row, and stray starts or idle-time data. The same holds for the table contents read back through the read port.

// File: rtl/pivot_pkg.sv
package pivot_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MAG_W  = DATA_W - 1;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [MAG_W-1:0]  mag_t;

  // sign bit dropped; unsigned order of the rest matches |x| for finite values
  function automatic mag_t mag_of(word_t w);
    return w[MAG_W-1:0];
  endfunction
endpackage

// File: rtl/piv_ctrl.sv
module piv_ctrl #(
  parameter int unsigned ROW_W = 4,
  localparam int unsigned N_W  = ROW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] col_i,
  input  logic [N_W-1:0]   n_i,
  input  logic             valid_i,
  input  logic             cmp_last_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ROW_W-1:0] k_o,
  output logic             fin_o,
  output logic             clr_o,
  output logic             acc_o,
  output logic [ROW_W-1:0] idx_o,
  output logic             last_o
);
  logic             busy_q, done_q, fin_q, fin_go_q;
  logic [N_W-1:0]   rem_q;
  logic [ROW_W-1:0] idx_q, k_q;
  logic             start_acc, is_final, finish;

  assign start_acc = start_i && !busy_q;
  assign is_final  = ({1'b0, col_i} + N_W'(1)) >= n_i;
  assign acc_o     = valid_i && busy_q && (rem_q != '0);
  assign last_o    = rem_q == N_W'(1);
  assign finish    = busy_q && (cmp_last_i || fin_go_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fin_q    <= 1'b0;
      fin_go_q <= 1'b0;
      rem_q    <= '0;
      idx_q    <= '0;
      k_q      <= '0;
    end else begin
      done_q <= finish;
      if (start_acc) begin
        busy_q   <= 1'b1;
        k_q      <= col_i;
        idx_q    <= '0;
        fin_q    <= is_final;
        fin_go_q <= is_final;
        rem_q    <= is_final ? '0 : n_i - {1'b0, col_i};
      end else begin
        fin_go_q <= 1'b0;
        if (finish) busy_q <= 1'b0;
        if (acc_o) begin
          rem_q <= rem_q - N_W'(1);
          idx_q <= idx_q + ROW_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign k_o    = k_q;
  assign fin_o  = fin_q;
  assign clr_o  = start_acc;
  assign idx_o  = idx_q;
endmodule

// File: rtl/piv_cmp_pipe.sv
module piv_cmp_pipe
  import pivot_pkg::*;
#(
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_vld_i,
  input  word_t            in_data_i,
  input  logic [ROW_W-1:0] in_idx_i,
  input  logic             in_last_i,
  output mag_t             best_mag_o,
  output logic [ROW_W-1:0] best_idx_o,
  output logic             last_o
);
  // stage 1: capture
  logic             s1_vld, s1_first, s1_last;
  mag_t             s1_mag;
  logic [ROW_W-1:0] s1_idx;
  // stage 2: running best
  mag_t             best_mag;
  logic [ROW_W-1:0] best_idx;
  logic             last_q, take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_mag   <= '0;
      s1_idx   <= '0;
    end else if (clr_i) begin
      s1_vld   <= 1'b0;
    end else begin
      s1_vld   <= in_vld_i;
      s1_first <= in_idx_i == '0;
      s1_last  <= in_last_i;
      s1_mag   <= mag_of(in_data_i);
      s1_idx   <= in_idx_i;
    end
  end

  // strict greater keeps the earlier row on ties
  assign take = s1_vld && (s1_first || (s1_mag > best_mag));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_mag <= '0;
      best_idx <= '0;
      last_q   <= 1'b0;
    end else if (clr_i) begin
      best_mag <= '0;
      best_idx <= '0;
      last_q   <= 1'b0;
    end else begin
      last_q <= s1_vld && s1_last;
      if (take) begin
        best_mag <= s1_mag;
        best_idx <= s1_idx;
      end
    end
  end

  assign best_mag_o = best_mag;
  assign best_idx_o = best_idx;
  assign last_o     = last_q;
endmodule

// File: rtl/piv_table.sv
module piv_table #(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ROW_W-1:0] waddr_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic [ROW_W-1:0] raddr_i,
  output logic [ROW_W-1:0] rdata_o
);
  logic [ROW_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[g] <= '0;
      else if (we_i && (waddr_i == ROW_W'(g)))      ent_q[g] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/pivot_search.sv
module pivot_search
  import pivot_pkg::*;
#(
  parameter int unsigned N_MAX = 16,
  localparam int unsigned ROW_W = $clog2(N_MAX),
  localparam int unsigned N_W   = ROW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] col_i,
  input  logic [N_W-1:0]   n_i,
  input  logic             valid_i,
  input  logic [31:0]      data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ROW_W-1:0] piv_row_o,
  output logic             piv_zero_o,
  input  logic [ROW_W-1:0] tbl_raddr_i,
  output logic [ROW_W-1:0] tbl_rdata_o
);
  logic             clr, acc, elem_last, cmp_last, fin;
  logic [ROW_W-1:0] k, idx, best_idx;
  mag_t             best_mag;

  piv_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .col_i      (col_i),
    .n_i        (n_i),
    .valid_i    (valid_i),
    .cmp_last_i (cmp_last),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .k_o        (k),
    .fin_o      (fin),
    .clr_o      (clr),
    .acc_o      (acc),
    .idx_o      (idx),
    .last_o     (elem_last)
  );

  piv_cmp_pipe #(.ROW_W(ROW_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .in_vld_i   (acc),
    .in_data_i  (data_i),
    .in_idx_i   (idx),
    .in_last_i  (elem_last),
    .best_mag_o (best_mag),
    .best_idx_o (best_idx),
    .last_o     (cmp_last)
  );

  assign piv_row_o  = k + best_idx;
  assign piv_zero_o = !fin && (best_mag == '0);

  piv_table #(.ROW_W(ROW_W), .DEPTH(N_MAX)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done_o),
    .waddr_i (k),
    .wdata_i (piv_row_o),
    .raddr_i (tbl_raddr_i),
    .rdata_o (tbl_rdata_o)
  );
endmodule

// File: rtl/pivot_search_chk.sv
module pivot_search_chk #(
  parameter int unsigned ROW_W = 4,
  localparam int unsigned N_W  = ROW_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [ROW_W-1:0] col_i,
  input logic [N_W-1:0]   n_i,
  input logic             valid_i,
  input logic [31:0]      data_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ROW_W-1:0] piv_row_o,
  input logic             piv_zero_o
);
  logic [N_W-1:0]   rem_c, n_c;
  logic [ROW_W-1:0] k_c;
  logic [30:0]      max_c;
  logic             fin_c, l1, l2, l3, fd1, fd2, st, acc, fin_now;

  assign st      = start_i && !busy_o;
  assign acc     = valid_i && busy_o && (rem_c != '0);
  assign fin_now = ({1'b0, col_i} + N_W'(1)) >= n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_c <= '0; n_c <= '0; k_c <= '0; max_c <= '0; fin_c <= 1'b0;
      l1 <= 1'b0; l2 <= 1'b0; l3 <= 1'b0; fd1 <= 1'b0; fd2 <= 1'b0;
    end else begin
      l2  <= l1;
      l3  <= l2;
      fd2 <= fd1;
      fd1 <= st && fin_now;
      l1  <= acc && (rem_c == N_W'(1));
      if (st) begin
        k_c   <= col_i;
        n_c   <= n_i;
        fin_c <= fin_now;
        max_c <= '0;
        rem_c <= fin_now ? '0 : n_i - {1'b0, col_i};
      end else if (acc) begin
        rem_c <= rem_c - N_W'(1);
        if (data_i[30:0] > max_c) max_c <= data_i[30:0];
      end
    end
  end

  a_r4_done_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (l3 || fd2));
  a_r4_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l3 |-> done_o);
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_row_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fin_c) |-> (piv_row_o >= k_c && {1'b0, piv_row_o} < n_c));
  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (piv_zero_o == (!fin_c && max_c == '0)));
  a_r7_final_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fin_c) |-> (piv_row_o == k_c && !piv_zero_o));
  a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));
endmodule

bind pivot_search pivot_search_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .col_i      (col_i),
  .n_i        (n_i),
  .valid_i    (valid_i),
  .data_i     (data_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .piv_row_o  (piv_row_o),
  .piv_zero_o (piv_zero_o)
);

// File: tb/pivot_search_tb.sv
`timescale 1ns/1ps
module pivot_search_tb;
  localparam int N_MAX = 16;
  localparam int ROW_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [ROW_W-1:0] col_i = '0;
  logic [ROW_W:0]   n_i = '0;
  logic             valid_i = 1'b0;
  logic [31:0]      data_i = '0;
  logic             busy_o, done_o, piv_zero_o;
  logic [ROW_W-1:0] piv_row_o, tbl_rdata_o;
  logic [ROW_W-1:0] tbl_raddr_i = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] vals [N_MAX];

  always #4 clk = ~clk;

  pivot_search #(.N_MAX(N_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .col_i(col_i), .n_i(n_i),
    .valid_i(valid_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
    .piv_row_o(piv_row_o), .piv_zero_o(piv_zero_o),
    .tbl_raddr_i(tbl_raddr_i), .tbl_rdata_o(tbl_rdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_row(input int k, input int n);
    int best = k;
    for (int i = k + 1; i < n; i++)
      if (vals[i][30:0] > vals[best][30:0]) best = i;
    return best;
  endfunction

  function automatic bit exp_zero(input int k, input int n);
    for (int i = k; i < n; i++)
      if (vals[i][30:0] != 0) return 1'b0;
    return 1'b1;
  endfunction

  // gaps: insert idle cycles; stray: start pulse mid-run and junk data after
  task automatic run_col(input int k, input int n, input bit gaps, input bit stray,
                         input string req);
    int er = exp_row(k, n);
    bit ez = exp_zero(k, n);
    // junk while idle (R8)
    @(negedge clk);
    valid_i = 1'b1; data_i = 32'h7F7F_FFFF;
    @(negedge clk);
    start_i = 1'b1; col_i = ROW_W'(k); n_i = (ROW_W+1)'(n);
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    for (int i = 0; i < n - k; i++) begin
      if (gaps) begin
        int g = $urandom % 3;
        for (int j = 0; j < g; j++) begin
          valid_i = 1'b0; data_i = 32'h7F00_0000;
          @(negedge clk);
        end
      end
      valid_i = 1'b1; data_i = vals[k + i];
      if (stray && i == 1) begin
        start_i = 1'b1; col_i = ROW_W'(n - 1); n_i = (ROW_W+1)'(n);
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    // junk after the column is complete (R8)
    valid_i = stray; data_i = 32'h7F7F_FFFF;
    chk(done_o == 1'b0, "R4 no early done", done_o, 0);
    @(negedge clk);
    valid_i = 1'b0;
    chk(done_o == 1'b0, "R4 no early done", done_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, {req, " R4 done"}, done_o, 1);
    chk(piv_row_o == ROW_W'(er), {req, " R1 pivot row"}, piv_row_o, er);
    chk(piv_zero_o == ez, {req, " R6 zero flag"}, piv_zero_o, ez);
    chk(busy_o == 1'b0, "R8 busy falls with done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R4 single pulse", done_o, 0);
    tbl_raddr_i = ROW_W'(k);
    #1;
    chk(tbl_rdata_o == ROW_W'(er), "R5 table entry", tbl_rdata_o, er);
  endtask

  task automatic run_final(input int k, input int n);
    @(negedge clk);
    start_i = 1'b1; col_i = ROW_W'(k); n_i = (ROW_W+1)'(n);
    valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0 && busy_o == 1'b1, "R7 final wait", done_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R7 final done", done_o, 1);
    chk(piv_row_o == ROW_W'(k), "R7 final row", piv_row_o, k);
    chk(piv_zero_o == 1'b0, "R7 final zero flag", piv_zero_o, 0);
    @(negedge clk);
    tbl_raddr_i = ROW_W'(k);
    #1;
    chk(tbl_rdata_o == ROW_W'(k), "R7 final table", tbl_rdata_o, k);
  endtask

  function automatic logic [31:0] rnd_word(input bit tiny);
    logic [31:0] w;
    if (tiny) begin
      case ($urandom % 3)
        0: w = 32'h0000_0000;
        1: w = 32'h3F80_0000;
        default: w = 32'h4000_0000;
      endcase
      w[31] = $urandom % 2;
    end else begin
      w = $urandom & 32'hFF7F_FFFF; // exponent never all ones
    end
    return w;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R9 reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R9 reset done", done_o, 0);
    tbl_raddr_i = 4'd5; #1;
    chk(tbl_rdata_o == '0, "R9 reset table", tbl_rdata_o, 0);
    rst_ni = 1'b1;

    // R1 plain, back-to-back
    for (int i = 0; i < N_MAX; i++) vals[i] = 32'h3F80_0000 + (i * 32'h0010_0000);
    vals[5] = 32'h4200_0000;
    run_col(2, 9, 1'b0, 1'b0, "R1 directed");
    // R2 negative wins
    for (int i = 0; i < N_MAX; i++) vals[i] = 32'h4000_0000;
    vals[7] = 32'hC300_0000;
    run_col(3, 12, 1'b0, 1'b0, "R2 negative max");
    // R3 ties, lower row kept, mixed signs
    for (int i = 0; i < N_MAX; i++) vals[i] = 32'h3F00_0000;
    vals[6] = 32'hC100_0000; vals[9] = 32'h4100_0000; vals[12] = 32'hC100_0000;
    run_col(4, 16, 1'b0, 1'b0, "R3 tie");
    // R6 all zeros with both signs
    for (int i = 0; i < N_MAX; i++) vals[i] = (i % 2) ? 32'h8000_0000 : 32'h0;
    run_col(0, 16, 1'b1, 1'b0, "R6 all zero");
    // R6 single nonzero at the last row
    vals[15] = 32'h8000_0001;
    run_col(10, 16, 1'b0, 1'b0, "R6 tiny nonzero");
    // R8 stray start and junk data
    for (int i = 0; i < N_MAX; i++) vals[i] = rnd_word(1'b0);
    run_col(1, 14, 1'b1, 1'b1, "R8 stray start");
    // R7 final column
    run_final(15, 16);
    run_final(7, 8);
    // R1 two-element column
    vals[14] = 32'h3F80_0000; vals[15] = 32'hBF80_0001;
    run_col(14, 16, 1'b0, 1'b0, "R1 short");

    // R10 random streams with gaps
    for (int r = 0; r < 40; r++) begin
      int n = 2 + ($urandom % (N_MAX - 1));
      int k = $urandom % (n - 1);
      bit tiny = (r % 3) == 0;
      for (int i = 0; i < N_MAX; i++) vals[i] = rnd_word(tiny);
      run_col(k, n, r % 2, r % 5 == 0, "R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule